// File: doc/BRIEF.md
# Shared-Clock Dual-Port RAM with Collision Flags

This block is a synchronous RAM with two independent ports on one clock. Each port has an enable, a write strobe, an address, write data and a registered read word, and either port can reach any location on any cycle. Each port has its own write-behaviour parameter, chosen when the block is instantiated. A read-first port returns the word that was stored before its write. A write-first port returns the word it is writing. A no-change port keeps its previous read word during a write.

When both ports touch the same address in the same enabled cycle, the block applies fixed rules. The writing port's mode decides what the other port may see. When the read word cannot be trusted, the block raises a registered per-port invalid flag next to that word and never returns undefined data. When both ports write different data to one location, port A's data is stored and both ports are flagged. DEPTH must be a power of two. The address width is its base-2 logarithm.

Top module: `dp_collide_ram`

## Requirements
- R1: After reset both read words are zero and both invalid flags are low. The array holds all zeros before any write, so a read returns 0.
- R2: While a port's enable is low, its read word and invalid flag hold their values and its write strobe changes no location.
- R3: An enabled read with the write strobe low returns the addressed word one clock later. Both ports may read one address in the same cycle, each gets the stored word and neither is flagged.
- R4: An enabled write stores its data. Later reads from either port return it.
- R5: On a write by a read-first port, that port's read word becomes the word that was at the address before the write.
- R6: On a write by a write-first port, that port's read word becomes the data being written, one clock later.
- R7: On a write by a no-change port, that port's read word keeps its previous value. Reads on that port update it normally.
- R8: When both ports write the same address in one cycle with equal data, the data is stored and neither flag rises.
- R9: When both ports write the same address in one cycle with unequal data, both invalid flags rise one clock later and port A's data is what stays stored.
- R10: When one port writes and the other reads the same address in one cycle, and the writing port is read-first, the reader gets the previous word with its flag low. The write is stored.
- R11: In that same collision with a write-first or no-change writer, the reader's invalid flag rises whatever the reader's own mode. The write is stored.
- R12: An invalid flag drops on the port's next enabled access that is not itself a collision for that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| pa_en | input | 1 | Port A enable |
| pa_we | input | 1 | Port A write strobe |
| pa_addr | input | AW | Port A address, AW = log2(DEPTH) |
| pa_wdata | input | WIDTH | Port A write data |
| pa_rdata | output | WIDTH | Port A registered read word |
| pa_rd_invalid | output | 1 | Port A read word not reliable |
| pb_en | input | 1 | Port B enable |
| pb_we | input | 1 | Port B write strobe |
| pb_addr | input | AW | Port B address |
| pb_wdata | input | WIDTH | Port B write data |
| pb_rdata | output | WIDTH | Port B registered read word |
| pb_rd_invalid | output | 1 | Port B read word not reliable |

## Verification
The bench builds two copies with WIDTH 8 and DEPTH 16, and drives both with the same stimulus. The first pairs a read-first port A with a write-first port B. The second pairs a no-change port A with a read-first port B. Between them, every writer mode meets a reader across a same-address collision in both directions. This shows that the writer's mode alone decides the outcome, while the small depth keeps the addresses easy to follow.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

    typedef enum logic [1:0] {
        WM_READ_FIRST  = 2'd0,
        WM_WRITE_FIRST = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wmode_t;

    localparam int NPORTS = 2;

    // Same-cycle relation between the two port requests
    typedef struct packed {
        logic       same_addr;
        logic       both_write;
        logic       write_mismatch;
        logic [1:0] read_hit;   // [p]: port p reads where the peer writes
    } clash_t;

    // A writer in this mode lets the colliding reader see the old word safely
    function automatic logic shields_reader(input wmode_t m);
        return m == WM_READ_FIRST;
    endfunction

    function automatic int peer_of(input int p);
        return (p == 0) ? 1 : 0;
    endfunction

endpackage

// File: rtl/dpr_clash_detect.sv
module dpr_clash_detect
    import dpram_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int AW    = 6
) (
    input  logic [1:0]       en,
    input  logic [1:0]       we,
    input  logic [AW-1:0]    addr0,
    input  logic [AW-1:0]    addr1,
    input  logic [WIDTH-1:0] wdata0,
    input  logic [WIDTH-1:0] wdata1,
    output clash_t           clash
);
    logic hit;

    always_comb begin
        hit                  = en[0] && en[1] && (addr0 == addr1);
        clash.same_addr      = hit;
        clash.both_write     = hit && we[0] && we[1];
        clash.write_mismatch = hit && we[0] && we[1] && (wdata0 != wdata1);
        clash.read_hit[0]    = hit && !we[0] && we[1];
        clash.read_hit[1]    = hit && !we[1] && we[0];
    end
endmodule

// File: rtl/dpr_store.sv
module dpr_store #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_a,
    input  logic [AW-1:0]    addr_a,
    input  logic [WIDTH-1:0] data_a,
    input  logic             wr_b,
    input  logic [AW-1:0]    addr_b,
    input  logic [WIDTH-1:0] data_b,
    output logic [WIDTH-1:0] word_a,
    output logic [WIDTH-1:0] word_b
);
    logic [WIDTH-1:0] mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    end

    // Port A is written last so it wins a same-address double write
    always_ff @(posedge clk) begin
        if (wr_b) mem[addr_b] <= data_b;
        if (wr_a) mem[addr_a] <= data_a;
    end

    // Pre-write contents; the port output stage registers them
    assign word_a = mem[addr_a];
    assign word_b = mem[addr_b];
endmodule

// File: rtl/dpr_port_out.sv
module dpr_port_out
    import dpram_pkg::*;
#(
    parameter int     WIDTH = 16,
    parameter wmode_t MODE  = WM_READ_FIRST
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             we,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] stored,
    input  logic             rd_collide,
    input  logic             wr_mismatch,
    output logic [WIDTH-1:0] rdata,
    output logic             invalid
);
    logic [WIDTH-1:0] wr_view;

    // Word presented by this port during its own write, chosen by mode
    always_comb begin
        case (MODE)
            WM_READ_FIRST:  wr_view = stored;
            WM_WRITE_FIRST: wr_view = wdata;
            default:        wr_view = rdata;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata   <= '0;
            invalid <= 1'b0;
        end else if (en) begin
            if (we) begin
                rdata   <= wr_view;
                invalid <= wr_mismatch;
            end else begin
                rdata   <= stored;
                invalid <= rd_collide;
            end
        end
    end
endmodule

// File: rtl/dp_collide_ram.sv
module dp_collide_ram
    import dpram_pkg::*;
#(
    parameter int     WIDTH  = 16,
    parameter int     DEPTH  = 64,
    parameter wmode_t MODE_A = WM_READ_FIRST,
    parameter wmode_t MODE_B = WM_WRITE_FIRST,
    localparam int    AW     = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pa_en,
    input  logic             pa_we,
    input  logic [AW-1:0]    pa_addr,
    input  logic [WIDTH-1:0] pa_wdata,
    output logic [WIDTH-1:0] pa_rdata,
    output logic             pa_rd_invalid,
    input  logic             pb_en,
    input  logic             pb_we,
    input  logic [AW-1:0]    pb_addr,
    input  logic [WIDTH-1:0] pb_wdata,
    output logic [WIDTH-1:0] pb_rdata,
    output logic             pb_rd_invalid
);
    logic [NPORTS-1:0] en_v, we_v, rd_bad, inv_v;
    logic [WIDTH-1:0]  wd_v   [NPORTS];
    logic [WIDTH-1:0]  word_v [NPORTS];
    logic [WIDTH-1:0]  rd_v   [NPORTS];
    clash_t            clash;

    assign en_v  = {pb_en, pa_en};
    assign we_v  = {pb_we, pa_we};
    assign wd_v[0] = pa_wdata;
    assign wd_v[1] = pb_wdata;

    dpr_clash_detect #(.WIDTH(WIDTH), .AW(AW)) u_detect (
        .en     (en_v),
        .we     (we_v),
        .addr0  (pa_addr),
        .addr1  (pb_addr),
        .wdata0 (pa_wdata),
        .wdata1 (pb_wdata),
        .clash  (clash)
    );

    dpr_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .wr_a   (pa_en && pa_we),
        .addr_a (pa_addr),
        .data_a (pa_wdata),
        .wr_b   (pb_en && pb_we),
        .addr_b (pb_addr),
        .data_b (pb_wdata),
        .word_a (word_v[0]),
        .word_b (word_v[1])
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        localparam wmode_t OWN_MODE  = (p == 0) ? MODE_A : MODE_B;
        localparam wmode_t PEER_MODE = (p == 0) ? MODE_B : MODE_A;

        // Only the writing peer's mode decides whether a colliding read is safe
        assign rd_bad[p] = clash.read_hit[p] && !shields_reader(PEER_MODE);

        dpr_port_out #(.WIDTH(WIDTH), .MODE(OWN_MODE)) u_out (
            .clk         (clk),
            .rst         (rst),
            .en          (en_v[p]),
            .we          (we_v[p]),
            .wdata       (wd_v[p]),
            .stored      (word_v[p]),
            .rd_collide  (rd_bad[p]),
            .wr_mismatch (clash.write_mismatch),
            .rdata       (rd_v[p]),
            .invalid     (inv_v[p])
        );
    end

    assign pa_rdata      = rd_v[0];
    assign pb_rdata      = rd_v[1];
    assign pa_rd_invalid = inv_v[0];
    assign pb_rd_invalid = inv_v[1];
endmodule

// File: rtl/dp_collide_ram_chk.sv
module dp_collide_ram_chk
    import dpram_pkg::*;
#(
    parameter int     WIDTH  = 16,
    parameter int     DEPTH  = 64,
    parameter wmode_t MODE_A = WM_READ_FIRST,
    parameter wmode_t MODE_B = WM_WRITE_FIRST,
    localparam int    AW     = $clog2(DEPTH)
) (
    input logic             clk,
    input logic             rst,
    input logic             pa_en,
    input logic             pa_we,
    input logic [AW-1:0]    pa_addr,
    input logic [WIDTH-1:0] pa_wdata,
    input logic [WIDTH-1:0] pa_rdata,
    input logic             pa_rd_invalid,
    input logic             pb_en,
    input logic             pb_we,
    input logic [AW-1:0]    pb_addr,
    input logic [WIDTH-1:0] pb_wdata,
    input logic [WIDTH-1:0] pb_rdata,
    input logic             pb_rd_invalid
);
    logic meet;
    assign meet = pa_en && pb_en && (pa_addr == pb_addr);

    a_r2_hold_a: assert property (@(posedge clk) disable iff (rst)
        !pa_en |=> $stable(pa_rdata) && $stable(pa_rd_invalid));
    a_r2_hold_b: assert property (@(posedge clk) disable iff (rst)
        !pb_en |=> $stable(pb_rdata) && $stable(pb_rd_invalid));

    a_r6_wf_a: assert property (@(posedge clk) disable iff (rst)
        (MODE_A == WM_WRITE_FIRST) && pa_en && pa_we |=> pa_rdata == $past(pa_wdata));
    a_r6_wf_b: assert property (@(posedge clk) disable iff (rst)
        (MODE_B == WM_WRITE_FIRST) && pb_en && pb_we |=> pb_rdata == $past(pb_wdata));

    a_r7_nc_a: assert property (@(posedge clk) disable iff (rst)
        (MODE_A == WM_NO_CHANGE) && pa_en && pa_we |=> $stable(pa_rdata));
    a_r7_nc_b: assert property (@(posedge clk) disable iff (rst)
        (MODE_B == WM_NO_CHANGE) && pb_en && pb_we |=> $stable(pb_rdata));

    a_r9_mismatch: assert property (@(posedge clk) disable iff (rst)
        meet && pa_we && pb_we && (pa_wdata != pb_wdata) |=> pa_rd_invalid && pb_rd_invalid);

    a_r11_reader_b: assert property (@(posedge clk) disable iff (rst)
        (MODE_A != WM_READ_FIRST) && meet && pa_we && !pb_we |=> pb_rd_invalid);
    a_r11_reader_a: assert property (@(posedge clk) disable iff (rst)
        (MODE_B != WM_READ_FIRST) && meet && pb_we && !pa_we |=> pa_rd_invalid);

    a_r10_rf_safe_b: assert property (@(posedge clk) disable iff (rst)
        (MODE_A == WM_READ_FIRST) && meet && pa_we && !pb_we |=> !pb_rd_invalid);

    a_r12_clean_a: assert property (@(posedge clk) disable iff (rst)
        pa_en && !(meet && pb_we) |=> !pa_rd_invalid);
    a_r12_clean_b: assert property (@(posedge clk) disable iff (rst)
        pb_en && !(meet && pa_we) |=> !pb_rd_invalid);
endmodule

bind dp_collide_ram dp_collide_ram_chk #(
    .WIDTH(WIDTH), .DEPTH(DEPTH), .MODE_A(MODE_A), .MODE_B(MODE_B)
) u_chk (
    .clk(clk), .rst(rst),
    .pa_en(pa_en), .pa_we(pa_we), .pa_addr(pa_addr), .pa_wdata(pa_wdata),
    .pa_rdata(pa_rdata), .pa_rd_invalid(pa_rd_invalid),
    .pb_en(pb_en), .pb_we(pb_we), .pb_addr(pb_addr), .pb_wdata(pb_wdata),
    .pb_rdata(pb_rdata), .pb_rd_invalid(pb_rd_invalid)
);

// File: tb/dp_collide_ram_test.sv
module dp_collide_ram_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int D = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ae = 0, awe = 0, be = 0, bwe = 0;
    logic [3:0] aa = '0, ba = '0;
    logic [W-1:0] ad = '0, bd = '0;

    logic [W-1:0] a1, b1, a2, b2;
    logic ai1, bi1, ai2, bi2;
    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // A read-first, B write-first
    dp_collide_ram #(.WIDTH(W), .DEPTH(D),
        .MODE_A(dpram_pkg::WM_READ_FIRST), .MODE_B(dpram_pkg::WM_WRITE_FIRST)) uut (
        .clk(clk), .rst(rst),
        .pa_en(ae), .pa_we(awe), .pa_addr(aa), .pa_wdata(ad), .pa_rdata(a1), .pa_rd_invalid(ai1),
        .pb_en(be), .pb_we(bwe), .pb_addr(ba), .pb_wdata(bd), .pb_rdata(b1), .pb_rd_invalid(bi1));

    // A no-change, B read-first
    dp_collide_ram #(.WIDTH(W), .DEPTH(D),
        .MODE_A(dpram_pkg::WM_NO_CHANGE), .MODE_B(dpram_pkg::WM_READ_FIRST)) uut_nc (
        .clk(clk), .rst(rst),
        .pa_en(ae), .pa_we(awe), .pa_addr(aa), .pa_wdata(ad), .pa_rdata(a2), .pa_rd_invalid(ai2),
        .pb_en(be), .pb_we(bwe), .pb_addr(ba), .pb_wdata(bd), .pb_rdata(b2), .pb_rd_invalid(bi2));

    task automatic chk(input string req, input string what, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
        end
    endtask

    // Drive at a falling edge, then wait one full cycle for the registered result
    task automatic step(input logic e0, input logic w0, input logic [3:0] a0, input logic [W-1:0] d0,
                        input logic e1, input logic w1, input logic [3:0] a1i, input logic [W-1:0] d1);
        ae = e0; awe = w0; aa = a0; ad = d0;
        be = e1; bwe = w1; ba = a1i; bd = d1;
        @(negedge clk);
    endtask

    task automatic all_flags_low(input string req);
        chk(req, "flags uut", {4'b0, ai1, bi1, ai2, bi2}, 8'h00);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1", "reset rdata", a1 | b1 | a2 | b2, 8'h00);
        all_flags_low("R1");
        step(1, 0, 4'd5, 8'h00, 1, 0, 4'd5, 8'h00);
        chk("R1", "zero array read", a1 | b1 | a2 | b2, 8'h00);
        all_flags_low("R3");
    endtask

    task automatic t_single_writes;
        step(0, 0, 4'd0, 8'h00, 1, 1, 4'd2, 8'h22);
        chk("R6", "wf own write b1", b1, 8'h22);
        chk("R5", "rf own write b2", b2, 8'h00);
        chk("R2", "disabled a1", a1, 8'h00);
        step(1, 0, 4'd2, 8'h00, 1, 0, 4'd2, 8'h00);
        chk("R3", "dual read a1", a1, 8'h22);
        chk("R3", "dual read b1", b1, 8'h22);
        chk("R4", "dual read a2", a2, 8'h22);
        chk("R4", "dual read b2", b2, 8'h22);
        all_flags_low("R3");
        step(1, 1, 4'd7, 8'h33, 0, 0, 4'd0, 8'h00);
        chk("R5", "rf old word a1", a1, 8'h00);
        chk("R7", "nc hold a2", a2, 8'h22);
        chk("R2", "disabled b1", b1, 8'h22);
        step(1, 0, 4'd7, 8'h00, 0, 0, 4'd0, 8'h00);
        chk("R7", "nc read updates a2", a2, 8'h33);
        chk("R4", "readback a1", a1, 8'h33);
    endtask

    task automatic t_a_writes_b_reads;
        step(1, 1, 4'd7, 8'h44, 1, 0, 4'd7, 8'h00);
        chk("R10", "rf writer reader b1", b1, 8'h33);
        chk("R10", "rf writer flag bi1", {7'b0, bi1}, 8'h00);
        chk("R5", "rf writer own a1", a1, 8'h33);
        chk("R11", "nc writer flag bi2", {7'b0, bi2}, 8'h01);
        chk("R7", "nc writer own a2", a2, 8'h33);
        step(1, 0, 4'd7, 8'h00, 1, 0, 4'd7, 8'h00);
        chk("R10", "stored after collision", a1 & b1 & a2 & b2, 8'h44);
        chk("R12", "flag cleared bi2", {7'b0, bi2}, 8'h00);
    endtask

    task automatic t_b_writes_a_reads;
        step(1, 0, 4'd9, 8'h00, 1, 1, 4'd9, 8'h55);
        chk("R11", "wf writer flag ai1", {7'b0, ai1}, 8'h01);
        chk("R6", "wf writer own b1", b1, 8'h55);
        chk("R10", "rf writer reader a2", a2, 8'h00);
        chk("R10", "rf writer flag ai2", {7'b0, ai2}, 8'h00);
        step(0, 0, 4'd9, 8'h00, 1, 0, 4'd9, 8'h00);
        chk("R11", "write stored b1", b1, 8'h55);
        chk("R2", "flag held ai1", {7'b0, ai1}, 8'h01);
        step(1, 0, 4'd9, 8'h00, 0, 0, 4'd0, 8'h00);
        chk("R12", "flag cleared ai1", {7'b0, ai1}, 8'h00);
        chk("R12", "read after clear a1", a1, 8'h55);
    endtask

    task automatic t_double_writes;
        step(1, 1, 4'd4, 8'h66, 1, 1, 4'd4, 8'h66);
        all_flags_low("R8");
        chk("R7", "nc hold on double write a2", a2, 8'h55);
        step(1, 0, 4'd4, 8'h00, 1, 0, 4'd4, 8'h00);
        chk("R8", "equal data stored", a1 & b1 & a2 & b2, 8'h66);
        step(1, 1, 4'd4, 8'h77, 1, 1, 4'd4, 8'h88);
        chk("R9", "mismatch flags", {4'b0, ai1, bi1, ai2, bi2}, 8'h0F);
        chk("R6", "wf own on mismatch b1", b1, 8'h88);
        step(1, 0, 4'd4, 8'h00, 1, 0, 4'd4, 8'h00);
        chk("R9", "port A data kept", a1 & b1 & a2 & b2, 8'h77);
        chk("R9", "port A data kept (or)", a1 | b1 | a2 | b2, 8'h77);
        all_flags_low("R12");
    endtask

    task automatic t_disabled_write;
        step(0, 1, 4'd4, 8'h99, 0, 1, 4'd4, 8'hAA);
        chk("R2", "hold while disabled", a1 & b1 & a2 & b2, 8'h77);
        step(1, 0, 4'd4, 8'h00, 1, 0, 4'd4, 8'h00);
        chk("R2", "no write when disabled", a1 | b1 | a2 | b2, 8'h77);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset;
        t_single_writes;
        t_a_writes_b_reads;
        t_b_writes_a_reads;
        t_double_writes;
        t_disabled_write;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule